// File: doc/BRIEF.md
# I2C SCL Divisor Calculator

This block converts a functional clock frequency and a requested serial-clock frequency, both given in Hz, into the two divisor values that an I2C clock generator loads for its high and low phases. Each divisor step is worth 8 functional-clock cycles, so a phase lasts 8 × (divisor + 1) clocks.

The duty ratio is taken from a speed-mode table that is indexed by the requested rate. The high phase gets its share of the period, rounded up. The low phase gets the rounded-up whole period minus the high count, so the achieved SCL frequency stays close to the request. Both ceiling divisions run one after the other on a single restoring divider, which produces one quotient bit per cycle.

A one-cycle `start` pulse accepted while idle begins a calculation. A one-cycle `done` pulse presents the result, and the outputs then hold until the next `done`. A requested rate of zero finishes on the next cycle with `err` set.

Top module: `scl_divcalc`

## Requirements
- R1: The high:low duty ratio depends on the requested rate `scl_rate`. Up to 100000 Hz inclusive it is 40:47. Above that and up to 400000 Hz it is 6:13. Up to 1000000 Hz it is 26:50. Up to 1700000 Hz it is 12:32. Above 1700000 Hz it is 6:16.
- R2: The high count is ceil(`clk_rate` × H / (`scl_rate` × 8 × (H+L))), where H:L is the ratio selected by R1.
- R3: The low count is ceil(`clk_rate` / (`scl_rate` × 8)) minus the high count.
- R4: Each output divisor is its count minus 1. A count of 0 gives a divisor of 0, never a wrapped value. Only the lower 16 bits are presented.
- R5: When the rounded total is not larger than the high count, the low count is forced to 1, which gives `div_lo` = 0.
- R6: A request with `scl_rate` = 0 ends with `done` and `err` both high and both divisors at 0. A nonzero request ends with `err` low.
- R7: `done` is high for exactly one cycle per accepted request. `div_hi`, `div_lo` and `err` change only in a cycle where `done` is high.
- R8: While `busy` is high, `start` is ignored. The running calculation finishes with its own operands, and no extra `done` follows.
- R9: After reset, `busy`, `done` and `err` are low and both divisors are 0.
- R10: A 128000000 Hz clock with a 400000 Hz request gives counts of 13 and 27, so `div_hi` = 12 and `div_lo` = 26.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Functional clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Request pulse, accepted only while idle |
| clk_rate | input | 32 | Functional clock frequency in Hz |
| scl_rate | input | 32 | Requested SCL frequency in Hz |
| busy | output | 1 | Calculation in progress |
| done | output | 1 | One-cycle result strobe |
| err | output | 1 | Last request had a zero SCL rate |
| div_hi | output | 16 | High-phase divisor |
| div_lo | output | 16 | Low-phase divisor |

## Verification
Requests are placed on both sides of every mode threshold: exactly 100 kHz, 400 kHz, 1 MHz and 1.7 MHz, and one hertz above each. A wrong ratio choice or a strict-versus-inclusive comparison error therefore shows up as different divisors. Pairs are chosen so that one divides exactly and the other leaves a remainder, which separates a ceiling from a truncating division and shows whether the low phase comes from the total or from its own share. Tiny and zero clock rates drive the floor and zero-count paths. A zero SCL rate separates the error path from a normal result. A second request issued mid-calculation shows whether operands can be overwritten while busy.

// File: rtl/scl_div_pkg.sv
// Package: shared types and the speed-mode duty-ratio table for the
// SCL divisor calculator. Assumes ratios fit in RATIO_W bits.
package scl_div_pkg;

    localparam int RATIO_W = 8;

    typedef enum logic [2:0] {
        SPD_STD,
        SPD_FAST,
        SPD_FPLUS,
        SPD_HS_LO,
        SPD_HS_HI
    } speed_mode_t;

    typedef enum logic [1:0] {
        CS_IDLE,
        CS_HIGH,
        CS_TOTAL
    } calc_state_t;

    typedef struct packed {
        logic [RATIO_W-1:0] hi;
        logic [RATIO_W-1:0] lo;
    } duty_ratio_t;

    // Duty ratio (high, low) for each speed mode.
    function automatic duty_ratio_t mode_ratio(input speed_mode_t m);
        duty_ratio_t r;
        case (m)
            SPD_STD:   begin r.hi = 8'd40; r.lo = 8'd47; end
            SPD_FAST:  begin r.hi = 8'd6;  r.lo = 8'd13; end
            SPD_FPLUS: begin r.hi = 8'd26; r.lo = 8'd50; end
            SPD_HS_LO: begin r.hi = 8'd12; r.lo = 8'd32; end
            default:   begin r.hi = 8'd6;  r.lo = 8'd16; end
        endcase
        return r;
    endfunction

endpackage

// File: rtl/scl_ratio_sel.sv
// Module: scl_ratio_sel
// Classifies a requested SCL rate into a speed mode and returns the
// matching duty ratio. Purely combinational. Each threshold is an
// inclusive upper bound, and the thresholds must be given in rising order.
module scl_ratio_sel
    import scl_div_pkg::*;
#(
    parameter int RATE_W   = 32,
    parameter int LIM_STD  = 100000,
    parameter int LIM_FAST = 400000,
    parameter int LIM_FPLS = 1000000,
    parameter int LIM_HSLO = 1700000
) (
    input  logic [RATE_W-1:0]  scl_rate,
    output speed_mode_t        mode,
    output logic [RATIO_W-1:0] hi_ratio,
    output logic [RATIO_W-1:0] lo_ratio
);

    localparam int NLIM = 4;
    localparam logic [RATE_W-1:0] LIMS [NLIM] = '{
        RATE_W'(LIM_STD), RATE_W'(LIM_FAST), RATE_W'(LIM_FPLS), RATE_W'(LIM_HSLO)
    };

    logic [NLIM-1:0] above;
    duty_ratio_t     dr;

    // One comparator per threshold: rate strictly above that limit.
    for (genvar g = 0; g < NLIM; g++) begin : g_cmp
        assign above[g] = (scl_rate > LIMS[g]);
    end

    // The number of limits exceeded selects the mode.
    always_comb begin
        case ($countones(above))
            0:       mode = SPD_STD;
            1:       mode = SPD_FAST;
            2:       mode = SPD_FPLUS;
            3:       mode = SPD_HS_LO;
            default: mode = SPD_HS_HI;
        endcase
    end

    // Look up the ratio pair for the mode.
    always_comb dr = mode_ratio(mode);

    assign hi_ratio = dr.hi;
    assign lo_ratio = dr.lo;

endmodule

// File: rtl/scl_seq_divider.sv
// Module: scl_seq_divider
// Unsigned restoring divider that produces one quotient bit per cycle.
// A go pulse loads the operands. done pulses W+1 cycles later, and
// quo and rem then hold until the next go. Assumes den != 0.
module scl_seq_divider #(
    parameter int W = 64
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         go,
    input  logic [W-1:0] num,
    input  logic [W-1:0] den,
    output logic         done,
    output logic [W-1:0] quo,
    output logic [W-1:0] rem
);

    localparam int CW = $clog2(W + 1);

    logic [W-1:0]  q_r, r_r, d_r;
    logic [CW-1:0] cnt;
    logic          run;
    logic [W:0]    trial;
    logic [W:0]    diff;
    logic          fits;

    // Partial remainder shifted left by one, with the next dividend bit brought in.
    assign trial = {r_r, q_r[W-1]};
    assign diff  = trial - {1'b0, d_r};
    assign fits  = (trial >= {1'b0, d_r});

    // Load on go, then run one restoring step per cycle until cnt is spent.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_r  <= '0;
            r_r  <= '0;
            d_r  <= '0;
            cnt  <= '0;
            run  <= 1'b0;
            done <= 1'b0;
        end else begin
            done <= 1'b0;
            if (go) begin
                q_r <= num;
                r_r <= '0;
                d_r <= den;
                cnt <= CW'(W);
                run <= 1'b1;
            end else if (run) begin
                q_r <= {q_r[W-2:0], fits};
                r_r <= fits ? diff[W-1:0] : trial[W-1:0];
                cnt <= cnt - 1'b1;
                if (cnt == CW'(1)) begin
                    run  <= 1'b0;
                    done <= 1'b1;
                end
            end
        end
    end

    assign quo = q_r;
    assign rem = r_r;

endmodule

// File: rtl/scl_divcalc.sv
// Module: scl_divcalc (top)
// Computes the high and low SCL phase divisors from the clock rate and the
// requested SCL rate. The high count is a rounded-up share of the period.
// The low count is the rounded-up period minus the high count, with a floor
// of 1. Both divisions share one sequential divider. Assumes the inputs are
// stable only in the start cycle, so the operands are captured there.
module scl_divcalc
    import scl_div_pkg::*;
#(
    parameter int RATE_W = 32,
    parameter int DIV_W  = 16,
    parameter int DVD_W  = 64,
    parameter int STEP_SHIFT = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [RATE_W-1:0] clk_rate,
    input  logic [RATE_W-1:0] scl_rate,
    output logic              busy,
    output logic              done,
    output logic              err,
    output logic [DIV_W-1:0]  div_hi,
    output logic [DIV_W-1:0]  div_lo
);

    calc_state_t        st;
    speed_mode_t        mode;
    logic [RATIO_W-1:0] hr, lr;
    logic [RATE_W-1:0]  clk_q, scl_q;
    logic [DVD_W-1:0]   num_r, den_r;
    logic               go_r;
    logic               dv_done;
    logic [DVD_W-1:0]   dv_quo, dv_rem;
    logic [DVD_W-1:0]   ceil_q;
    logic [DVD_W-1:0]   hi_cnt;
    logic [DVD_W-1:0]   lo_cnt;
    logic [DVD_W-1:0]   ratio_sum;

    scl_ratio_sel #(.RATE_W(RATE_W)) u_sel (
        .scl_rate (scl_rate),
        .mode     (mode),
        .hi_ratio (hr),
        .lo_ratio (lr)
    );

    scl_seq_divider #(.W(DVD_W)) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .go    (go_r),
        .num   (num_r),
        .den   (den_r),
        .done  (dv_done),
        .quo   (dv_quo),
        .rem   (dv_rem)
    );

    // Sum of the two ratio terms, widened to the dividend width.
    assign ratio_sum = DVD_W'(hr) + DVD_W'(lr);

    // Ceiling of the divider result: add one when the remainder is not zero.
    assign ceil_q = dv_quo + DVD_W'(dv_rem != '0);

    // Low count: rounded total minus the high count, never below 1.
    always_comb begin
        if (ceil_q > hi_cnt) lo_cnt = ceil_q - hi_cnt;
        else                 lo_cnt = DVD_W'(1);
    end

    // Sequencing: capture, high share, total, publish.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st     <= CS_IDLE;
            go_r   <= 1'b0;
            num_r  <= '0;
            den_r  <= '0;
            clk_q  <= '0;
            scl_q  <= '0;
            hi_cnt <= '0;
            done   <= 1'b0;
            err    <= 1'b0;
            div_hi <= '0;
            div_lo <= '0;
        end else begin
            go_r <= 1'b0;
            done <= 1'b0;
            case (st)
                CS_IDLE: begin
                    if (start) begin
                        clk_q <= clk_rate;
                        scl_q <= scl_rate;
                        if (scl_rate == '0) begin
                            done   <= 1'b1;
                            err    <= 1'b1;
                            div_hi <= '0;
                            div_lo <= '0;
                        end else begin
                            num_r <= DVD_W'(clk_rate) * DVD_W'(hr);
                            den_r <= (DVD_W'(scl_rate) << STEP_SHIFT) * ratio_sum;
                            go_r  <= 1'b1;
                            st    <= CS_HIGH;
                        end
                    end
                end
                CS_HIGH: begin
                    if (dv_done) begin
                        hi_cnt <= ceil_q;
                        num_r  <= DVD_W'(clk_q);
                        den_r  <= DVD_W'(scl_q) << STEP_SHIFT;
                        go_r   <= 1'b1;
                        st     <= CS_TOTAL;
                    end
                end
                CS_TOTAL: begin
                    if (dv_done) begin
                        done   <= 1'b1;
                        err    <= 1'b0;
                        div_hi <= (hi_cnt == '0) ? '0 : DIV_W'(hi_cnt - 1'b1);
                        div_lo <= DIV_W'(lo_cnt - 1'b1);
                        st     <= CS_IDLE;
                    end
                end
                default: st <= CS_IDLE;
            endcase
        end
    end

    assign busy = (st != CS_IDLE);

endmodule

// File: rtl/scl_divcalc_chk.sv
// Module: scl_divcalc_chk
// Protocol checker for scl_divcalc, attached through bind. It observes
// ports only and keeps one register: the SCL rate of the accepted request.
module scl_divcalc_chk #(
    parameter int RATE_W = 32,
    parameter int DIV_W  = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic [RATE_W-1:0] scl_rate,
    input logic              busy,
    input logic              done,
    input logic              err,
    input logic [DIV_W-1:0]  div_hi,
    input logic [DIV_W-1:0]  div_lo
);

    logic [RATE_W-1:0] req_scl;

    // Remember the SCL rate of each request that is accepted while idle.
    always_ff @(posedge clk) begin
        if (!rst_n)               req_scl <= '0;
        else if (start && !busy)  req_scl <= scl_rate;
    end

    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);                                                   // R7
    AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> ($stable(div_hi) && $stable(div_lo) && $stable(err)));   // R7
    AST_ERR_ZERO_OUT: assert property (@(posedge clk) disable iff (!rst_n)
        (done && err) |-> (div_hi == '0 && div_lo == '0));                 // R6
    AST_ERR_MATCHES_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (err == (req_scl == '0)));                                // R6
    AST_BUSY_ENDS_IN_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> (busy || done));                                          // R8
    AST_NO_DONE_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !done);                                                   // R8

endmodule

bind scl_divcalc scl_divcalc_chk #(.RATE_W(RATE_W), .DIV_W(DIV_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .scl_rate (scl_rate),
    .busy     (busy),
    .done     (done),
    .err      (err),
    .div_hi   (div_hi),
    .div_lo   (div_lo)
);

// File: tb/sim_scl_divcalc.sv
// Directed bench for scl_divcalc. Each scenario is a task that checks its
// own results against a reference computed from the requirements.
module sim_scl_divcalc;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] clk_rate = '0;
    logic [31:0] scl_rate = '0;
    logic        busy, done, err;
    logic [15:0] div_hi, div_lo;

    int n_vec  = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    scl_divcalc u0 (
        .clk(clk), .rst_n(rst_n), .start(start),
        .clk_rate(clk_rate), .scl_rate(scl_rate),
        .busy(busy), .done(done), .err(err),
        .div_hi(div_hi), .div_lo(div_lo)
    );

    task automatic check(input string req, input longint act, input longint exp);
        n_vec++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Reference model taken from R1..R5.
    task automatic ref_calc(input longint unsigned c, input longint unsigned s,
                            output longint unsigned dh, output longint unsigned dl);
        longint unsigned h, l, den, hc, tot, lc;
        if (s <= 100000)       begin h = 40; l = 47; end
        else if (s <= 400000)  begin h = 6;  l = 13; end
        else if (s <= 1000000) begin h = 26; l = 50; end
        else if (s <= 1700000) begin h = 12; l = 32; end
        else                   begin h = 6;  l = 16; end
        den = s * 8 * (h + l);
        hc  = (c * h + den - 1) / den;
        tot = (c + s * 8 - 1) / (s * 8);
        lc  = (tot > hc) ? tot - hc : 1;
        dh  = (hc == 0) ? 0 : hc - 1;
        dl  = lc - 1;
        dh  = dh & 16'hFFFF;
        dl  = dl & 16'hFFFF;
    endtask

    // Issue one request, wait for done, and sample at the falling edge.
    task automatic issue(input logic [31:0] c, input logic [31:0] s, output bit got);
        got = 1'b0;
        @(negedge clk);
        clk_rate = c; scl_rate = s; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int i = 0; i < 400; i++) begin
            if (done) begin got = 1'b1; break; end
            @(negedge clk);
        end
    endtask

    task automatic run_vec(input string req, input logic [31:0] c, input logic [31:0] s);
        longint unsigned eh, el;
        bit got;
        ref_calc(c, s, eh, el);
        issue(c, s, got);
        check({req, " done seen"}, got, 1);
        check({req, " div_hi"}, div_hi, eh);
        check({req, " div_lo"}, div_lo, el);
        check({req, " err"}, err, 0);
        @(negedge clk);
        check("R7 done one cycle", done, 0);
    endtask

    task automatic t_reset();
        check("R9 busy", busy, 0);
        check("R9 done", done, 0);
        check("R9 err", err, 0);
        check("R9 div_hi", div_hi, 0);
        check("R9 div_lo", div_lo, 0);
    endtask

    task automatic t_example();
        bit got;
        issue(32'd128000000, 32'd400000, got);
        check("R10 done", got, 1);
        check("R10 div_hi", div_hi, 12);
        check("R10 div_lo", div_lo, 26);
        issue(32'd50000000, 32'd100000, got);
        check("R1 std div_hi", div_hi, 28);
        check("R1 std div_lo", div_lo, 33);
        issue(32'd50000000, 32'd100001, got);
        check("R1 fast div_hi", div_hi, 19);
        check("R1 fast div_lo", div_lo, 42);
    endtask

    task automatic t_modes();
        run_vec("R1 100k", 32'd48000000, 32'd100000);
        run_vec("R1 100k+1", 32'd48000000, 32'd100001);
        run_vec("R1 400k", 32'd48000000, 32'd400000);
        run_vec("R1 400k+1", 32'd48000000, 32'd400001);
        run_vec("R1 1M", 32'd200000000, 32'd1000000);
        run_vec("R1 1M+1", 32'd200000000, 32'd1000001);
        run_vec("R1 1.7M", 32'd200000000, 32'd1700000);
        run_vec("R1 1.7M+1", 32'd200000000, 32'd1700001);
        run_vec("R1 3.4M", 32'd400000000, 32'd3400000);
    endtask

    task automatic t_rounding();
        run_vec("R2 R3 exact", 32'd70400000, 32'd100000);
        run_vec("R2 R3 remainder", 32'd99999999, 32'd333333);
        run_vec("R2 R3 large clk", 32'hFFFFFFFF, 32'd100000);
        run_vec("R4 trunc16", 32'hFFFFFFFF, 32'd1);
    endtask

    task automatic t_floor();
        bit got;
        issue(32'd8, 32'd1, got);      // high 1, total 1 -> low clamped
        check("R5 div_hi", div_hi, 0);
        check("R5 div_lo", div_lo, 0);
        issue(32'd0, 32'd100000, got); // high count 0
        check("R4 zero count div_hi", div_hi, 0);
        check("R4 zero count div_lo", div_lo, 0);
        run_vec("R5 tiny", 32'd100, 32'd2000000);
    endtask

    task automatic t_zero_scl();
        bit got;
        issue(32'd128000000, 32'd400000, got);
        issue(32'd50000000, 32'd0, got);
        check("R6 done", got, 1);
        check("R6 err", err, 1);
        check("R6 div_hi", div_hi, 0);
        check("R6 div_lo", div_lo, 0);
        @(negedge clk);
        check("R7 err held", err, 1);
        run_vec("R6 err clears", 32'd128000000, 32'd400000);
    endtask

    task automatic t_busy_ignore();
        int dones = 0;
        @(negedge clk);
        clk_rate = 32'd128000000; scl_rate = 32'd400000; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (10) @(negedge clk);
        check("R8 busy mid", busy, 1);
        clk_rate = 32'd1000; scl_rate = 32'd0; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int i = 0; i < 400; i++) begin
            if (done) begin
                dones++;
                check("R8 div_hi", div_hi, 12);
                check("R8 div_lo", div_lo, 26);
                check("R8 err", err, 0);
            end
            @(negedge clk);
        end
        check("R8 single done", dones, 1);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_example();
        t_modes();
        t_rounding();
        t_floor();
        t_zero_scl();
        t_busy_ignore();
        if (!finished) begin
            finished = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
            $finish;
        end
    end

endmodule